// File: doc/BRIEF.md
# Converter Result Read Port

This block is the read side of a 12-bit converter that sits on a microprocessor bus. It keeps the finished conversion result in a holding register and presents it on twelve data lines. Each line has its own output enable, so a pad ring or a testbench can model the tri-state behaviour. The lines are enabled only while the host is actually reading: read/convert high, chip enable high, active-low chip select low, and the converter not busy.

A format input picks how the result is presented. In wide mode all twelve lines carry the result at once and the byte address is ignored. In byte mode the result is split into two bytes for an 8-bit bus, left-justified. With the byte address low, the upper eight lines carry the eight most significant bits. With it high, the top four lines float, the next four are driven to zero, and the bottom four carry the four least significant bits.

Whenever the byte address changes in byte mode, every line is released for exactly one clock cycle before the new group drives. The two byte groups therefore never overlap.

Top module: `adc_rd_bus_if`

## Requirements
- R1: All twelve output enables are 0 unless rd_conv=1, busy=0, chip_en=1 and chip_sel_n=0 hold in the same cycle.
- R2: Any line whose output enable is 0 reads 0 on the data vector.
- R3: With fmt_wide=1 and access granted, all twelve enables are 1 and the data equals the held result; byte_addr has no effect and its changes cause no idle cycle.
- R4: With fmt_wide=0, byte_addr=0 (stable) and access granted, lines 11:4 are enabled with result bits 11:4 and lines 3:0 are disabled.
- R5: With fmt_wide=0, byte_addr=1 (stable) and access granted, lines 11:8 are disabled, lines 7:4 are enabled and drive 0, and lines 3:0 carry result bits 3:0.
- R6: In byte mode, no line of 11:8 is enabled in the same cycle as any line of 3:0.
- R7: In byte mode, in the cycle where byte_addr differs from its value at the previous clock edge, all enables are 0; from the next cycle the newly selected group drives.
- R8: The held result resets to 0 and loads result_in only at a clock edge where conv_done=1; otherwise, changes on result_in do not reach the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Load strobe: a conversion finished this cycle |
| result_in | input | 12 | Conversion result to be held |
| busy | input | 1 | Converter status, high while converting |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | Read/convert, high for read |
| fmt_wide | input | 1 | 1: 12-line format, 0: two-byte format |
| byte_addr | input | 1 | Byte select in two-byte format, 0 = high byte |
| dq_out | output | 12 | Data value per line |
| dq_oe | output | 12 | Output enable per line |

## Verification
The assertions check, on every cycle, that the lines are released without full access and that the wide format enables all lines. They also check that the upper and lowest groups never drive together in byte mode, that a byte-address change blanks the outputs, and that the presented wide data only moves after a load. The exact lane contents in each format, the zero nibble in the low byte, and the return to driving after the dead cycle are shown only by the bench. The same holds for the claim that result_in is ignored without a load. The bench runs all sixteen access combinations in each format and byte address, plus random sequences checked against its own model.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    LANE_OFF  = 2'd0,
    LANE_WIDE = 2'd1,
    LANE_HIGH = 2'd2,
    LANE_LOW  = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/adc_rd_result_reg.sv
module adc_rd_result_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] res_d;

  // hold unless a conversion has just finished (R8)
  always_comb begin
    res_d = res_q;
    if (load) res_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign dout = res_q;
endmodule

// File: rtl/adc_rd_a0_guard.sv
module adc_rd_a0_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_mode,
  input  logic addr,
  output logic blank
);
  logic addr_q;
  logic addr_d;

  always_comb begin
    addr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= 1'b0;
    else        addr_q <= addr_d;
  end

  // one idle cycle whenever the byte address moves (R7)
  assign blank = byte_mode & (addr ^ addr_q);
endmodule

// File: rtl/adc_rd_lane_steer.sv
module adc_rd_lane_steer
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  lane_mode_e        mode,
  input  logic [DATA_W-1:0] res,
  output logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] oe
);
  localparam int LOW_W = DATA_W - BYTE_W;

  for (genvar i = 0; i < DATA_W; i++) begin : g_line
    logic en;
    logic val;
    always_comb begin
      en  = 1'b0;
      val = 1'b0;
      unique case (mode)
        LANE_WIDE: begin
          en  = 1'b1;
          val = res[i];
        end
        LANE_HIGH: begin
          en  = (i >= LOW_W);
          val = res[i];
        end
        LANE_LOW: begin
          en  = (i < BYTE_W);
          val = (i < LOW_W) ? res[i] : 1'b0;
        end
        default: begin
          en  = 1'b0;
          val = 1'b0;
        end
      endcase
    end
    assign oe[i] = en;
    assign dq[i] = en & val;
  end
endmodule

// File: rtl/adc_rd_bus_if.sv
module adc_rd_bus_if
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] result_in,
  input  logic              busy,
  input  logic              chip_en,
  input  logic              chip_sel_n,
  input  logic              rd_conv,
  input  logic              fmt_wide,
  input  logic              byte_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe
);
  logic [DATA_W-1:0] held;
  logic              access;
  logic              blank;
  lane_mode_e        mode;

  adc_rd_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n), .load(conv_done), .din(result_in), .dout(held)
  );

  adc_rd_a0_guard u_guard (
    .clk(clk), .rst_n(rst_n), .byte_mode(~fmt_wide), .addr(byte_addr), .blank(blank)
  );

  assign access = rd_conv & ~busy & chip_en & ~chip_sel_n;

  always_comb begin
    if (!access)      mode = LANE_OFF;
    else if (fmt_wide) mode = LANE_WIDE;
    else if (blank)   mode = LANE_OFF;
    else if (byte_addr) mode = LANE_LOW;
    else              mode = LANE_HIGH;
  end

  adc_rd_lane_steer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_steer (
    .mode(mode), .res(held), .dq(dq_out), .oe(dq_oe)
  );
endmodule

// File: rtl/adc_rd_bus_if_chk.sv
module adc_rd_bus_if_chk #(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic              busy,
  input logic              chip_en,
  input logic              chip_sel_n,
  input logic              rd_conv,
  input logic              fmt_wide,
  input logic              byte_addr,
  input logic [DATA_W-1:0] dq_out,
  input logic [DATA_W-1:0] dq_oe
);
  localparam int LOW_W = DATA_W - BYTE_W;
  logic acc;
  assign acc = rd_conv & ~busy & chip_en & ~chip_sel_n;

  a_r1_idle_without_access: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> (dq_oe == '0));

  a_r3_wide_all_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fmt_wide) |-> (dq_oe == '1));

  a_r6_groups_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_wide |-> !((|dq_oe[DATA_W-1:BYTE_W]) && (|dq_oe[LOW_W-1:0])));

  a_r7_blank_on_addr_move: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !fmt_wide && (byte_addr != $past(byte_addr))) |-> (dq_oe == '0));

  a_r8_data_holds_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && acc && fmt_wide && $past(acc && fmt_wide && !conv_done))
      |-> (dq_out == $past(dq_out)));
endmodule

bind adc_rd_bus_if adc_rd_bus_if_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .busy(busy),
  .chip_en(chip_en), .chip_sel_n(chip_sel_n), .rd_conv(rd_conv),
  .fmt_wide(fmt_wide), .byte_addr(byte_addr), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/adc_rd_bus_if_bench.sv
module adc_rd_bus_if_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_done, busy, chip_en, chip_sel_n, rd_conv, fmt_wide, byte_addr;
  logic [11:0] result_in;
  logic [11:0] dq_out, dq_oe;
  int          checks = 0;
  int          errors = 0;
  logic [11:0] m_res;
  logic        m_a0p;

  always #10 clk = ~clk;

  adc_rd_bus_if u_adc_rd_bus_if (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .result_in(result_in),
    .busy(busy), .chip_en(chip_en), .chip_sel_n(chip_sel_n), .rd_conv(rd_conv),
    .fmt_wide(fmt_wide), .byte_addr(byte_addr), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // bench-side model of the two state bits
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_res <= '0;
      m_a0p <= 1'b0;
    end else begin
      if (conv_done) m_res <= result_in;
      m_a0p <= byte_addr;
    end
  end

  function automatic logic [23:0] expect_bus(logic [11:0] r, logic a0p);
    logic acc;
    acc = rd_conv && !busy && chip_en && !chip_sel_n;
    if (!acc)                return 24'h0;
    if (fmt_wide)            return {12'hFFF, r};
    if (byte_addr != a0p)    return 24'h0;
    if (!byte_addr)          return {12'hFF0, r & 12'hFF0};
    return {12'h0FF, 8'h00, r[3:0]};
  endfunction

  function automatic string pick_tag(logic a0p);
    if (!(rd_conv && !busy && chip_en && !chip_sel_n)) return "R1";
    if (fmt_wide)          return "R3";
    if (byte_addr != a0p)  return "R7";
    return byte_addr ? "R5" : "R4";
  endfunction

  task automatic check_now(string tag);
    logic [23:0] e;
    e = expect_bus(m_res, m_a0p);
    checks++;
    if ({dq_oe, dq_out} !== e) begin
      errors++;
      $display("FAIL %s: oe=%h dq=%h expected oe=%h dq=%h", tag, dq_oe, dq_out, e[23:12], e[11:0]);
    end
    checks++;
    if ((dq_out & ~dq_oe) !== 12'h0) begin
      errors++;
      $display("FAIL R2: dq=%h oe=%h expected disabled lines 0", dq_out, dq_oe);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic settle_and_check(string tag);
    #5;
    check_now(tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a0c));
    rst_n = 1'b0; conv_done = 0; busy = 0; chip_en = 1; chip_sel_n = 0;
    rd_conv = 1; fmt_wide = 1; byte_addr = 0; result_in = 12'hABC;
    repeat (3) @(negedge clk);
    #5 check_now("R8");            // reset: held result 0
    @(negedge clk); rst_n = 1'b1;

    // R8: load while busy, then read in wide format
    @(negedge clk); busy = 1; conv_done = 1; result_in = 12'hA5C;
    #5 check_now("R1");
    @(negedge clk); conv_done = 0; busy = 0; result_in = 12'h3F0;
    #5 check_now("R8");
    @(negedge clk); #5 check_now("R8");

    // all 16 access combinations, both formats, both byte addresses
    for (int f = 0; f < 2; f++) begin
      for (int a = 0; a < 2; a++) begin
        @(negedge clk); fmt_wide = f[0]; byte_addr = a[0];
        rd_conv = 0;
        @(negedge clk);            // let the address settle
        for (int c = 0; c < 16; c++) begin
          @(negedge clk);
          rd_conv = c[0]; busy = c[1]; chip_en = c[2]; chip_sel_n = c[3];
          #5 check_now(pick_tag(m_a0p));
        end
      end
    end

    // R7 directed: toggle byte address under access in byte mode
    @(negedge clk); rd_conv = 1; busy = 0; chip_en = 1; chip_sel_n = 0;
    fmt_wide = 0; byte_addr = 0;
    @(negedge clk); #5 check_now("R4");
    @(negedge clk); byte_addr = 1; #5 check_now("R7");
    @(negedge clk); #5 check_now("R5");
    @(negedge clk); byte_addr = 0; #5 check_now("R7");
    @(negedge clk); #5 check_now("R6");
    // R3: wide format ignores address toggles
    @(negedge clk); fmt_wide = 1; byte_addr = 1; #5 check_now("R3");
    @(negedge clk); byte_addr = 0; #5 check_now("R3");

    // random mix
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      conv_done  = ($urandom % 5) == 0;
      result_in  = 12'($urandom);
      busy       = ($urandom % 4) == 0;
      chip_en    = ($urandom % 6) != 0;
      chip_sel_n = ($urandom % 6) == 0;
      rd_conv    = ($urandom % 5) != 0;
      fmt_wide   = ($urandom % 3) == 0;
      if (($urandom % 3) == 0) byte_addr = ~byte_addr;
      #5 check_now(pick_tag(m_a0p));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule